// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer with Mode Register

This block keeps the programmed operating mode of a two-bank SDRAM and uses it to produce the column addresses of each read or write burst. A mode-load strobe presents a 10-bit word (bank-select bit plus nine address bits). The block checks that word, decodes it and stores it. It then exposes the CAS latency and the write-opcode field that the rest of the controller needs.

A burst-start strobe presents an 8-bit starting column. From the next cycle on, the block emits one column address per clock, in sequential or interleaved order, over 1, 2, 4, 8 or 256 beats. The final address is marked with a last-beat flag. The block refuses words that carry a reserved code, raises an illegal-mode flag for them, and keeps the previous settings.

Top module: `sdr_burst_colgen`

## Requirements
- R1: After reset the block holds burst length 1, sequential order, CAS latency 2 and opcode field 00. It shows `mode_illegal` low and `col_valid` low.
- R2: Mode word fields are: bits 2:0 length code, bit 3 order (0 sequential, 1 interleaved), bits 6:4 latency code, bits 8:7 opcode, bit 9 bank select. A legal word loaded with `mrs_stb` updates `cas_lat` on the next cycle. Latency codes 001, 010 and 011 show as binary 1, 2 and 3. The same load copies bits 8:7 to `wr_op` and clears `mode_illegal`.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. Code 111 with sequential order gives 256 beats.
- R4: In sequential order the low address bits covered by the length count up from the start column and wrap inside the aligned block. The upper bits stay fixed. A 256-beat burst wraps modulo 256.
- R5: In interleaved order the covered low bits of beat i equal the start column's low bits XOR i, and the upper bits stay fixed.
- R6: A word is rejected if it has any of these: length code 100, 101 or 110; length code 111 with interleaved order; latency code 000 or 1xx; bank bit 1. On a rejected load, `mode_illegal` goes high on the next cycle and all settings stay unchanged. The flag stays high until a legal word is loaded.
- R7: Without a `mrs_stb`, the stored settings and `mode_illegal` do not change.
- R8: The first column equals `burst_col` and appears the cycle after `burst_stb`. After that, one column follows per cycle. `col_valid` is high for exactly the burst length. `col_last` is high only with the final column.
- R9: A `burst_stb` during a burst restarts the sequence from the new start column on the next cycle.
- R10: Length and order are captured at `burst_stb`. A mode load during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_stb | input | 1 | Load mode word |
| mrs_word | input | 10 | Mode word: bank bit and nine address bits |
| burst_stb | input | 1 | Start a burst |
| burst_col | input | 8 | Starting column |
| col_addr | output | 8 | Current column address |
| col_valid | output | 1 | Column address is part of a burst |
| col_last | output | 1 | Final beat of the burst |
| cas_lat | output | 2 | Decoded CAS latency |
| wr_op | output | 2 | Stored opcode field |
| mode_illegal | output | 1 | Last loaded word was rejected |

## Verification
Mode results (`cas_lat`, `wr_op`, `mode_illegal`) change at the first rising edge after `mrs_stb` is sampled. Beat 0 of a burst appears at the first edge after `burst_stb`, and beat i appears i edges later. `col_valid` falls one edge after the last beat. The bench drives inputs on falling edges and samples on the next falling edge, which is half a period after the edge the result is due from. It derives the expected columns with modulo and XOR arithmetic on integers, without reusing the mask-based form in the design.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  localparam int COL_W   = 8;
  localparam int MR_W    = 10;
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int OP_LSB  = 7;
  localparam int BNK_BIT = 9;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  typedef struct packed {
    logic [COL_W-1:0] mask;
    order_e           ord;
    logic [1:0]       cas;
    logic [1:0]       op;
  } mode_t;

  // length code legal for the given order
  function automatic logic bl_ok(logic [2:0] code, order_e ord);
    case (code)
      3'b000, 3'b001, 3'b010, 3'b011: return 1'b1;
      3'b111:                         return ord == ORD_SEQ;
      default:                        return 1'b0;
    endcase
  endfunction

  // beats-1 as a low-bit mask
  function automatic logic [COL_W-1:0] bl_mask(logic [2:0] code);
    case (code)
      3'b000:  return COL_W'(0);
      3'b001:  return COL_W'(1);
      3'b010:  return COL_W'(3);
      3'b011:  return COL_W'(7);
      default: return '1;
    endcase
  endfunction

  function automatic logic cl_ok(logic [2:0] code);
    return (code[2] == 1'b0) && (code[1:0] != 2'b00);
  endfunction

  // column of a beat: low bits move, upper bits kept
  function automatic logic [COL_W-1:0] beat_col(logic [COL_W-1:0] base,
                                                logic [COL_W-1:0] beat,
                                                logic [COL_W-1:0] mask,
                                                order_e ord);
    logic [COL_W-1:0] off;
    off = (ord == ORD_ILV) ? (base ^ beat) : (base + beat);
    return (base & ~mask) | (off & mask);
  endfunction
endpackage

// File: rtl/sdr_mode_store.sv
module sdr_mode_store
  import sdr_burst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MR_W-1:0] word,
  output mode_t           mode,
  output logic            illegal
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;
  order_e     ord_in;
  logic       legal;
  logic       ev_load_ok;
  logic       ev_load_bad;
  mode_t      cand;

  always_comb begin
    bl_code     = word[BL_LSB +: 3];
    cl_code     = word[CL_LSB +: 3];
    ord_in      = order_e'(word[BT_BIT]);
    legal       = bl_ok(bl_code, ord_in) && cl_ok(cl_code) && !word[BNK_BIT];
    ev_load_ok  = load && legal;
    ev_load_bad = load && !legal;
    cand.mask   = bl_mask(bl_code);
    cand.ord    = ord_in;
    cand.cas    = cl_code[1:0];
    cand.op     = word[OP_LSB +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '{mask: '0, ord: ORD_SEQ, cas: 2'd2, op: 2'b00};
      illegal <= 1'b0;
    end else if (ev_load_ok) begin
      mode    <= cand;
      illegal <= 1'b0;
    end else if (ev_load_bad) begin
      illegal <= 1'b1;
    end
  end

  assert_bad_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_bad |=> illegal);
  assert_bad_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_bad |=> $stable(mode));
  assert_ok_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_ok |=> !illegal && (mode.cas != 2'd0));
  assert_retain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode) && $stable(illegal));
endmodule

// File: rtl/sdr_beat_track.sv
module sdr_beat_track
  import sdr_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] mask_in,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] lim,
  output logic             active,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat   <= '0;
      lim    <= '0;
      active <= 1'b0;
    end else if (start) begin
      beat   <= '0;
      lim    <= mask_in;
      active <= 1'b1;
    end else if (active) begin
      if (beat == lim) active <= 1'b0;
      else             beat   <= beat + COL_W'(1);
    end
  end

  assign last = active && (beat == lim);

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last && !start |=> !active);
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && (beat == '0));
  assert_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((beat & ~lim) == '0));
endmodule

// File: rtl/sdr_col_path.sv
module sdr_col_path
  import sdr_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] col_in,
  input  order_e           ord_in,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] lim,
  output order_e           ord_q,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ord_q  <= ORD_SEQ;
    end else if (start) begin
      base_q <= col_in;
      ord_q  <= ord_in;
    end
  end

  assign col = beat_col(base_q, beat, lim, ord_q);

  assert_ord_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ord_q) && $stable(base_q));
endmodule

// File: rtl/sdr_burst_colgen.sv
module sdr_burst_colgen
  import sdr_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_stb,
  input  logic [MR_W-1:0]  mrs_word,
  input  logic             burst_stb,
  input  logic [COL_W-1:0] burst_col,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic [1:0]       wr_op,
  output logic             mode_illegal
);
  mode_t            mode;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] lim;
  order_e           ord_q;

  sdr_mode_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mrs_stb),
    .word    (mrs_word),
    .mode    (mode),
    .illegal (mode_illegal)
  );

  sdr_beat_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (burst_stb),
    .mask_in (mode.mask),
    .beat    (beat),
    .lim     (lim),
    .active  (col_valid),
    .last    (col_last)
  );

  sdr_col_path u_path (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (burst_stb),
    .col_in (burst_col),
    .ord_in (mode.ord),
    .beat   (beat),
    .lim    (lim),
    .ord_q  (ord_q),
    .col    (col_addr)
  );

  assign cas_lat = mode.cas;
  assign wr_op   = mode.op;

  assert_first_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stb |=> col_valid && (col_addr == $past(burst_col)));
  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !burst_stb && (ord_q == ORD_SEQ) |=>
      (((col_addr - $past(col_addr)) & $past(lim)) == COL_W'(1)));
  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && !burst_stb |=>
      (((col_addr ^ $past(col_addr)) & ~$past(lim)) == '0));
  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
endmodule

// File: tb/test_sdr_burst_colgen.sv
module test_sdr_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_stb = 1'b0;
  logic [9:0] mrs_word = '0;
  logic       burst_stb = 1'b0;
  logic [7:0] burst_col = '0;
  logic [7:0] col_addr;
  logic       col_valid, col_last, mode_illegal;
  logic [1:0] cas_lat, wr_op;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdr_burst_colgen i_sdr_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mrs_stb(mrs_stb), .mrs_word(mrs_word),
    .burst_stb(burst_stb), .burst_col(burst_col), .col_addr(col_addr),
    .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat),
    .wr_op(wr_op), .mode_illegal(mode_illegal)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mw(bit bank, int op, int cl, bit bt, int bl);
    return {bank, 2'(op), 3'(cl), bt, 3'(bl)};
  endfunction

  function automatic int exp_col(int s, int i, int len, bit ilv);
    int off = s % len;
    int base = s - off;
    if (ilv) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic load_mode(logic [9:0] w, int exp_ill, int exp_cas, string req);
    mrs_word = w; mrs_stb = 1'b1;
    @(negedge clk);
    mrs_stb = 1'b0;
    chk({req, " illegal"}, int'(mode_illegal), exp_ill);
    chk({req, " cas"}, int'(cas_lat), exp_cas);
  endtask

  task automatic check_beat(int s, int i, int len, bit ilv, string req);
    chk({req, " valid"}, int'(col_valid), 1);
    chk({req, " col"}, int'(col_addr), exp_col(s, i, len, ilv));
    chk({req, " last"}, int'(col_last), int'(i == len - 1));
  endtask

  task automatic partial_burst(int s, int len, bit ilv, int k, string req);
    burst_col = 8'(s); burst_stb = 1'b1;
    @(negedge clk);
    burst_stb = 1'b0;
    for (int i = 0; i < k; i++) begin
      check_beat(s, i, len, ilv, req);
      @(negedge clk);
    end
  endtask

  task automatic run_burst(int s, int len, bit ilv, string req);
    partial_burst(s, len, ilv, len, req);
    chk({req, " end"}, int'(col_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 cas", int'(cas_lat), 2);
    chk("R1 illegal", int'(mode_illegal), 0);
    chk("R1 valid", int'(col_valid), 0);
    chk("R1 wr_op", int'(wr_op), 0);
    run_burst(8'h77, 1, 1'b0, "R1 burst");
  endtask

  task automatic t_seq();
    load_mode(mw(0, 2, 3, 0, 2), 0, 3, "R2 seq4");
    chk("R2 wr_op", int'(wr_op), 2);
    run_burst(8'h2E, 4, 1'b0, "R4 seq4");
    load_mode(mw(0, 0, 1, 0, 1), 0, 1, "R2 seq2");
    run_burst(8'h91, 2, 1'b0, "R3 seq2");
    load_mode(mw(0, 1, 2, 0, 3), 0, 2, "R2 seq8");
    chk("R2 wr_op1", int'(wr_op), 1);
    run_burst(8'hC5, 8, 1'b0, "R4 seq8");
    // idle cycles: settings held
    repeat (3) @(negedge clk);
    chk("R7 cas held", int'(cas_lat), 2);
    run_burst(8'h0F, 8, 1'b0, "R7 len held");
  endtask

  task automatic t_full_page();
    load_mode(mw(0, 0, 3, 0, 7), 0, 3, "R3 fp");
    run_burst(8'hFE, 256, 1'b0, "R4 fullpage");
  endtask

  task automatic t_ilv();
    load_mode(mw(0, 0, 2, 1, 3), 0, 2, "R5 ilv8");
    run_burst(8'h35, 8, 1'b1, "R5 ilv8");
    load_mode(mw(0, 0, 2, 1, 2), 0, 2, "R5 ilv4");
    run_burst(8'hA2, 4, 1'b1, "R5 ilv4");
    load_mode(mw(0, 0, 2, 1, 0), 0, 2, "R3 ilv1");
    run_burst(8'h3C, 1, 1'b1, "R3 ilv1");
  endtask

  task automatic t_illegal();
    load_mode(mw(0, 0, 3, 0, 2), 0, 3, "R6 base");
    load_mode(mw(0, 0, 1, 0, 4), 1, 3, "R6 bl100");
    load_mode(mw(0, 0, 1, 0, 6), 1, 3, "R6 bl110");
    load_mode(mw(0, 0, 1, 1, 7), 1, 3, "R6 fp ilv");
    load_mode(mw(0, 0, 0, 0, 3), 1, 3, "R6 cl000");
    load_mode(mw(0, 0, 5, 0, 3), 1, 3, "R6 cl1xx");
    load_mode(mw(1, 0, 1, 1, 3), 1, 3, "R6 bank");
    repeat (2) @(negedge clk);
    chk("R6 flag sticky", int'(mode_illegal), 1);
    chk("R6 wr_op kept", int'(wr_op), 0);
    run_burst(8'h4B, 4, 1'b0, "R6 kept");
    load_mode(mw(0, 3, 1, 1, 1), 0, 1, "R2 clear");
    run_burst(8'h0B, 2, 1'b1, "R5 ilv2");
  endtask

  task automatic t_restart();
    load_mode(mw(0, 0, 2, 0, 3), 0, 2, "R9 mode");
    partial_burst(8'h10, 8, 1'b0, 3, "R9 first");
    run_burst(8'h43, 8, 1'b0, "R9 restart");
  endtask

  task automatic t_mode_mid_burst();
    load_mode(mw(0, 0, 2, 0, 2), 0, 2, "R10 mode");
    partial_burst(8'h22, 4, 1'b0, 2, "R10 pre");
    mrs_word = mw(0, 0, 3, 1, 3); mrs_stb = 1'b1;
    check_beat(8'h22, 2, 4, 1'b0, "R10 beat2");
    @(negedge clk);
    mrs_stb = 1'b0;
    check_beat(8'h22, 3, 4, 1'b0, "R10 beat3");
    chk("R10 new cas", int'(cas_lat), 3);
    @(negedge clk);
    chk("R10 end", int'(col_valid), 0);
    run_burst(8'h22, 8, 1'b1, "R10 new mode");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_full_page();
    t_ilv();
    t_illegal();
    t_restart();
    t_mode_mid_burst();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule